// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block is the serial front end of a flash device, reduced to one job: answering the read-identification command. A host selects the device with an active-low chip enable, sends an opcode byte and a 24-bit address on the serial input, then keeps the serial clock running to collect identification bytes on the serial output. The output has a separate enable so that the pad can be tri-stated whenever the block is not returning data.

The host may run the bus with the clock idling low or idling high. The block records the clock level at the moment chip enable falls. Input bits are taken on rising clock edges and output bits change after falling clock edges, so both idle levels behave the same. All bus pins are brought into the system clock domain through a short synchronizer, and every action is taken on edges detected there. The serial clock must therefore run well below the system clock.

Address bit 0 selects the first byte returned: 0 gives the manufacturer code BFh and 1 gives the device code. After the first byte the two codes alternate for as long as chip enable stays low. The device code is a build parameter (43h for the 2 Mbit build, 44h for the 4 Mbit build), so one block serves both array sizes.

Top module: `spi_id_responder`

## Requirements
- R1: After reset, with chip enable high, `miso_oe` is 0.
- R2: With the clock idling low, opcode 90h followed by address 000000h returns BFh as the first output byte.
- R3: With the clock idling high at the fall of chip enable, the same command returns the same bytes as with the clock idling low.
- R4: Address bit 0 alone selects the first byte: 1 gives the device code and 0 gives BFh. Address bits 23 to 1 have no effect.
- R5: While chip enable stays low and the clock keeps running, output bytes alternate between BFh and the device code.
- R6: Every byte is shifted most significant bit first, on both input and output.
- R7: `miso_oe` stays 0 during the opcode and address bits. It rises only after the first falling clock edge that follows the last address bit.
- R8: While output is enabled, `miso` changes only after a falling clock edge. It holds its value across rising edges.
- R9: Raising chip enable at any point ends the transaction: `miso_oe` returns to 0 and the next transaction starts again from its first opcode bit.
- R10: An opcode other than 90h makes the block ignore the rest of the transaction. `miso_oe` stays 0 until chip enable goes high.
- R11: The serial input has no effect while identification bytes are being returned.
- R12: The device code equals the `DEV_ID` parameter: 43h by default, and 44h when built with `DEV_ID` = 44h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip enable from the host, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host, sampled on rising sck |
| miso | output | 1 | Serial data to the host, changed after falling sck |
| miso_oe | output | 1 | Output enable for the miso pad; 0 means high impedance |

## Verification
The hardest states to reach are edge cases in the clock sequence: the extra falling edge that appears when the clock idles high, and the first falling edge after the last address bit, which must start the output without shifting a bit too early. The bench drives each bit as a full low-then-high clock cycle. It samples the output just before every rising edge and again just after it, so both idle levels and the exact first output bit can be checked. Aborts are forced in the middle of the address phase and in the middle of an output byte, and a full read follows each one.

// File: rtl/spi_id_pkg.sv
// Shared constants and types for the identification responder.
// Assumes only that it is compiled before the modules that import it.
package spi_id_pkg;
    localparam logic [7:0] MFR_CODE     = 8'hBF;
    localparam logic [7:0] READ_ID_OP   = 8'h90;
    localparam logic [7:0] DEV_CODE_2M  = 8'h43;
    localparam logic [7:0] DEV_CODE_4M  = 8'h44;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_SEND = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;
endpackage

// File: rtl/spi_id_sync.sv
// Multi-stage synchronizer for a vector of asynchronous bus pins.
// It gives the synchronized value and the value one clock older, so
// that edges can be detected. Assumes all bits may be sampled together.
module spi_id_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q,
    output logic [W-1:0]  q_prev
);
    logic [STAGES:0][W-1:0] stg;

    // shift the pins through the synchronizer chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {(STAGES+1){RST_VAL}};
        else        stg <= {stg[STAGES-1:0], d};
    end

    assign q      = stg[STAGES-1];
    assign q_prev = stg[STAGES];
endmodule

// File: rtl/spi_id_rx.sv
// Receive side: shifts the opcode and the address in on rising sck,
// decides whether to answer, and records the clock idle level at
// chip-enable fall. Assumes edge pulses last exactly one clock.
module spi_id_rx
    import spi_id_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 24
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_s,      // synchronized chip enable (active low)
    input  logic   cs_p,      // chip enable one clock older
    input  logic   sck_s,     // synchronized clock level
    input  logic   mosi_s,    // synchronized data in
    input  logic   rise,      // rising sck pulse
    output logic   send,      // answer phase active
    output logic   first_sel  // 1: device code first, 0: maker code first
);
    localparam int MAXW = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
    localparam int CW   = $clog2(MAXW);

    phase_t            phase;
    logic [CW-1:0]     cnt;
    logic [CMD_W-2:0]  shreg;
    logic [CMD_W-1:0]  cmd_now;
    logic              mode_hi;

    assign cmd_now = {shreg, mosi_s};
    assign send    = (phase == PH_SEND);

    // latch clock idle level at the falling edge of chip enable
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_hi <= 1'b0;
        else if (!cs_s && cs_p)  mode_hi <= sck_s;
    end

    // opcode and address decoding on rising edges, cleared by chip enable high
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            shreg     <= '0;
            first_sel <= 1'b0;
        end else if (rise) begin
            case (phase)
                PH_CMD: begin
                    shreg <= cmd_now[CMD_W-2:0];
                    if (cnt == CW'(CMD_W-1)) begin
                        cnt   <= '0;
                        phase <= (cmd_now == READ_ID_OP) ? PH_ADDR : PH_SKIP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    if (cnt == CW'(ADDR_W-1)) begin
                        first_sel <= mosi_s;   // last address bit is bit 0
                        phase     <= PH_SEND;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: a rejected opcode keeps the block silent until chip enable rises
    p_skip_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP && !cs_s) |=> (phase == PH_SKIP));

    // R3: the recorded idle level does not move inside a transaction
    p_mode_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !cs_p) |=> $stable(mode_hi));

    // R7: the bit counter never runs past the address length
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAXW));
endmodule

// File: rtl/spi_id_tx.sv
// Transmit side: on each falling sck during the answer phase, drives the
// next bit of the current code, MSB first, and swaps codes per byte.
// Assumes send falls as soon as chip enable rises.
module spi_id_tx #(
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'h43
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  send,
    input  logic  first_sel,
    input  logic  fall,
    output logic  miso,
    output logic  miso_oe
);
    logic        tog;
    logic [2:0]  bitc;
    logic [7:0]  cur_byte;

    assign cur_byte = (first_sel ^ tog) ? DEV_ID : MFR_ID;

    // shift out code bits on falling edges, idle when not sending
    always_ff @(posedge clk) begin
        if (!rst_n || !send) begin
            miso    <= 1'b0;
            miso_oe <= 1'b0;
            bitc    <= 3'd7;
            tog     <= 1'b0;
        end else if (fall) begin
            miso    <= cur_byte[bitc];
            miso_oe <= 1'b1;
            bitc    <= bitc - 1'b1;
            if (bitc == 3'd0) tog <= ~tog;
        end
    end

    // R8: while enabled, the output moves only right after a falling edge
    p_change_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$stable(miso)) |-> $past(fall));

    // R7: enable is only raised inside the answer phase
    p_oe_in_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> $past(send));
endmodule

// File: rtl/spi_id_responder.sv
// Top level: synchronizes the bus pins to clk, detects sck edges, and
// joins the receive and transmit sides. Assumes sck is far slower than
// clk (at least eight clk periods per sck half-period).
module spi_id_responder
    import spi_id_pkg::*;
#(
    parameter logic [7:0] DEV_ID      = DEV_CODE_2M,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic [2:0] pins_s, pins_p;
    logic       cs_s, cs_p, sck_s, sck_p, mosi_s;
    logic       rise, fall, send, first_sel;

    spi_id_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}),
        .q(pins_s), .q_prev(pins_p)
    );

    assign {cs_s, sck_s, mosi_s} = pins_s;
    assign cs_p  = pins_p[2];
    assign sck_p = pins_p[1];
    assign rise  = !cs_s && sck_s && !sck_p;
    assign fall  = !cs_s && !sck_s && sck_p;

    spi_id_rx #(.CMD_W(8), .ADDR_W(24)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_p(cs_p), .sck_s(sck_s),
        .mosi_s(mosi_s), .rise(rise), .send(send), .first_sel(first_sel)
    );

    spi_id_tx #(.MFR_ID(MFR_CODE), .DEV_ID(DEV_ID)) u_tx (
        .clk(clk), .rst_n(rst_n), .send(send), .first_sel(first_sel),
        .fall(fall), .miso(miso), .miso_oe(miso_oe)
    );

    // R9: two clocks of deselect guarantee a released output
    p_release_on_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_s, 2) |-> !miso_oe);
endmodule

// File: tb/spi_id_responder_test.sv
// Directed bench for spi_id_responder: one task per scenario.
module spi_id_responder_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, miso4, miso_oe4;
    int   checks = 0, errors = 0;
    bit   done = 0;
    logic pre_miso, pre_oe, pre_miso4, post_miso;

    always #(CLK_P/2) clk = ~clk;

    spi_id_responder uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .mosi(mosi), .miso(miso), .miso_oe(miso_oe));
    spi_id_responder #(.DEV_ID(8'h44)) uut_4m (.clk(clk), .rst_n(rst_n),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso4), .miso_oe(miso_oe4));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    // one bit: low phase with data set, sample, rising edge, sample again
    task automatic bit_xfer(input logic din);
        sck = 1'b0; mosi = din;
        wait_h();
        pre_miso = miso; pre_oe = miso_oe; pre_miso4 = miso4;
        sck = 1'b1;
        wait_h();
        post_miso = miso;
    endtask

    task automatic begin_txn(input logic idle_hi);
        sck = idle_hi;
        wait_h();
        cs_n = 1'b0;
        wait_h();
    endtask

    task automatic end_txn(input logic idle_hi, input string req);
        if (!idle_hi) sck = 1'b0;
        wait_h();
        cs_n = 1'b1;
        wait_h(); wait_h();
        chk(req, {7'd0, miso_oe}, 8'd0);
        chk(req, {7'd0, miso_oe4}, 8'd0);
    endtask

    // shift a byte in; output must stay disabled (R7)
    task automatic send_byte(input logic [7:0] b);
        logic any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(b[i]);
            any_oe |= pre_oe;
        end
        chk("R7 oe low during command/address", {7'd0, any_oe}, 8'd0);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [23:0] addr);
        send_byte(op);
        send_byte(addr[23:16]);
        send_byte(addr[15:8]);
        send_byte(addr[7:0]);
    endtask

    // read one byte from both instances; check enable and R8 stability
    task automatic read_byte(input logic noise, output logic [7:0] r, output logic [7:0] r4);
        logic all_oe = 1'b1, stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(noise ? logic'(i % 2) : 1'b0);
            r[i] = pre_miso; r4[i] = pre_miso4;
            all_oe &= pre_oe;
            if (post_miso !== pre_miso) stable = 1'b0;
        end
        chk("R7 oe high during output", {7'd0, all_oe}, 8'd1);
        chk("R8 miso steady across rising edge", {7'd0, stable}, 8'd1);
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", {7'd0, miso_oe}, 8'd0);
        chk("R1 oe after reset (4M)", {7'd0, miso_oe4}, 8'd0);
    endtask

    task automatic t_mode0_alternate();
        logic [7:0] r, r4;
        begin_txn(1'b0);
        send_hdr(8'h90, 24'h000000);
        for (int k = 0; k < 4; k++) begin
            read_byte(1'b0, r, r4);
            chk(k == 0 ? "R2 R6 first byte maker code" : "R5 alternation",
                r, (k % 2 == 0) ? 8'hBF : 8'h43);
            chk("R12 device code 4M build", r4, (k % 2 == 0) ? 8'hBF : 8'h44);
        end
        end_txn(1'b0, "R9 released after mode 0 read");
    endtask

    task automatic t_mode3();
        logic [7:0] r, r4;
        begin_txn(1'b1);
        send_hdr(8'h90, 24'h000000);
        read_byte(1'b0, r, r4);
        chk("R3 idle-high first byte", r, 8'hBF);
        read_byte(1'b0, r, r4);
        chk("R3 idle-high second byte", r, 8'h43);
        end_txn(1'b1, "R9 released after mode 3 read");
    endtask

    task automatic t_addr1();
        logic [7:0] r, r4;
        begin_txn(1'b0);
        send_hdr(8'h90, 24'hABCD01);
        read_byte(1'b0, r, r4);
        chk("R4 address bit0=1 gives device code", r, 8'h43);
        chk("R4 R12 address bit0=1 (4M)", r4, 8'h44);
        read_byte(1'b0, r, r4);
        chk("R5 maker code follows", r, 8'hBF);
        read_byte(1'b0, r, r4);
        chk("R5 device code again", r, 8'h43);
        end_txn(1'b0, "R9 released after addr 1 read");
        begin_txn(1'b0);
        send_hdr(8'h90, 24'hFFFFFE);
        read_byte(1'b0, r, r4);
        chk("R4 upper address bits ignored", r, 8'hBF);
        end_txn(1'b0, "R9 released");
    endtask

    task automatic t_noise();
        logic [7:0] r, r4;
        begin_txn(1'b1);
        send_hdr(8'h90, 24'h000000);
        for (int k = 0; k < 3; k++) begin
            read_byte(1'b1, r, r4);
            chk("R11 input toggling during output", r, (k % 2 == 0) ? 8'hBF : 8'h43);
        end
        end_txn(1'b1, "R9 released after noisy read");
    endtask

    task automatic t_bad_op();
        logic any_oe = 1'b0;
        begin_txn(1'b0);
        send_hdr(8'h9F, 24'h000000);
        for (int i = 0; i < 16; i++) begin
            bit_xfer(1'b0);
            any_oe |= pre_oe;
        end
        chk("R10 no output after unknown opcode", {7'd0, any_oe}, 8'd0);
        end_txn(1'b0, "R10 still silent");
    endtask

    task automatic t_abort();
        logic [7:0] r, r4;
        begin_txn(1'b1);
        send_byte(8'h90);
        send_byte(8'h00);
        for (int i = 0; i < 3; i++) bit_xfer(1'b1);
        end_txn(1'b1, "R9 abort mid-address");
        begin_txn(1'b0);
        send_hdr(8'h90, 24'h000001);
        read_byte(1'b0, r, r4);
        chk("R9 fresh transaction after abort", r, 8'h43);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0);
        end_txn(1'b0, "R9 abort mid-output");
        begin_txn(1'b0);
        send_hdr(8'h90, 24'h000000);
        read_byte(1'b0, r, r4);
        chk("R9 restart after output abort", r, 8'hBF);
        end_txn(1'b0, "R9 released");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_mode0_alternate();
        t_mode3();
        t_addr1();
        t_noise();
        t_bad_op();
        t_abort();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule